// File: doc/BRIEF.md
# Strap-Selected Parallel Register Bus Slave

This block lets a microcontroller read and write a small bank of 16-bit registers over an asynchronous parallel bus. Two bus styles are supported. In the separate-strobe style the host has one active-low read strobe and one active-low write strobe. In the shared-strobe style the host has one active-low data strobe and a direction line, where high means read and low means write. A two-bit strap picks the style, and the block samples it once, on the first clock edge after reset is released.

Every access ends with an active-low acknowledge, so the host needs no wait-state counter. The acknowledge is open drain. The block only ever drives it low, and only while chip select is low. At all other times it leaves the line to a shared pull-up.

The asynchronous control pins (chip select and both strobes) pass through two-flop synchronizers in the system clock domain. Address, write data and byte enables are taken straight from the pins. The host must hold them stable while the strobe is low.

The bus handshake is the data-flow control here, so the block has no valid/ready ports. The acknowledge is the only back-pressure signal. The host may not end a strobe early, and an access that the host ends before the acknowledge arrives completes with no acknowledge.

Top module: `hostbus_slave`

## Requirements
- R1: Strap value 00 selects the separate-strobe style. `strobe0_n` low with `cs_n` low is a read. `strobe1_n` low with `cs_n` low is a write. If both strobes are low, the access is a read.
- R2: Strap value 01 selects the shared-strobe style. `strobe0_n` low with `cs_n` low starts an access. `strobe1_n` high makes it a read and `strobe1_n` low makes it a write.
- R3: Strap values 10 and 11 leave the port idle. `ack_oe` and `d_oe` stay low whatever the bus does.
- R4: The strap is captured on the first rising clock edge after `rst_n` goes high. Later changes on `mode_strap` have no effect until the next reset.
- R5: Whenever the acknowledge is driven, `ack_oe` is 1 and `ack_n` is 0. Otherwise `ack_n` is 1. `ack_oe` is 0 at any moment `cs_n` is high, and it drops in the same instant that `cs_n` rises.
- R6: For a read, `d_oe` rises and `d_out` holds the addressed word on the 3rd rising edge after the strobe falls. `ack_oe` follows ACK_DLY edges later (5th edge for the default of 2).
- R7: A write updates the register exactly once, on the 3rd rising edge after the strobe falls. `ack_oe` rises on the next edge (the 4th).
- R8: After the strobe returns high, the acknowledge stays driven and is released on rising edge 3+HOLD (5th for the default of 2).
- R9: `bhe_n` and `ble_n` are active low. `bhe_n` enables the upper byte (bits 15:8) of a write and `ble_n` enables the lower byte (bits 7:0). A read always returns all 16 bits.
- R10: `d_oe` is high only during a read with `cs_n` low. It falls in the same cycle that the acknowledge is released.
- R11: Addresses at or above NREGS (16) read as zero and ignore writes. They never alias onto a real register.
- R12: Reset clears all registers to zero and releases both `ack_oe` and `d_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_strap | input | 2 | Bus style strap, sampled after reset |
| cs_n | input | 1 | Active-low chip select |
| addr | input | 10 | Register address |
| strobe0_n | input | 1 | Read strobe (style 00) or data strobe (style 01) |
| strobe1_n | input | 1 | Write strobe (style 00) or read-high/write-low (style 01) |
| bhe_n | input | 1 | Upper byte enable, active low |
| ble_n | input | 1 | Lower byte enable, active low |
| d_in | input | 16 | Write data from host |
| d_out | output | 16 | Read data to host |
| d_oe | output | 1 | Drive enable for d_out |
| ack_n | output | 1 | Acknowledge value (low when driven) |
| ack_oe | output | 1 | Acknowledge drive enable |

## Verification
On every cycle, the assertions check four things:
- an idle strap never produces an acknowledge or output enable;
- the captured strap never changes between resets;
- a single write strobe produces exactly one register update;
- the read data is driven before the acknowledge rises, the acknowledge is released only from the hold phase, and the read enable falls together with it.

The bench scenarios cover the behaviour that needs a host model:
- the exact edge counts for acknowledge assertion and release;
- byte-lane merging;
- rejection of out-of-range addresses;
- the immediate release when chip select rises early;
- the fact that a strap change without a reset leaves the bus style unchanged.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
  typedef enum logic [1:0] {
    MODE_SEP   = 2'b00,
    MODE_SHR   = 2'b01,
    MODE_IDLE0 = 2'b10,
    MODE_IDLE1 = 2'b11
  } mode_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_WAIT = 2'b01,
    ST_ACK  = 2'b10,
    ST_HOLD = 2'b11
  } bus_st_t;
endpackage

// File: rtl/hbs_sync.sv
module hbs_sync #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      sync_q <= '1;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
    end
  end

  assign dout = sync_q;
endmodule

// File: rtl/hbs_regfile.sv
module hbs_regfile #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int NREGS  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [DATA_W/8-1:0]    lane_en,
  input  logic [ADDR_W-1:0]      waddr,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [ADDR_W-1:0]      raddr,
  output logic [DATA_W-1:0]      rdata
);
  localparam int LANES = DATA_W / 8;
  localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NREGS);

  logic [DATA_W-1:0] words [NREGS];
  logic              w_in_range, r_in_range;

  // R11: addresses at or above NREGS never reach a register
  assign w_in_range = (waddr < LIMIT);
  assign r_in_range = (raddr < LIMIT);

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    logic [DATA_W-1:0] word_q;
    logic              hit;
    assign hit = we && w_in_range && (waddr[IDX_W-1:0] == IDX_W'(r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (hit) begin
        for (int l = 0; l < LANES; l++) begin
          if (lane_en[l]) word_q[l*8 +: 8] <= wdata[l*8 +: 8];
        end
      end
    end

    assign words[r] = word_q;
  end

  assign rdata = r_in_range ? words[raddr[IDX_W-1:0]] : '0;
endmodule

// File: rtl/hbs_ctrl.sv
module hbs_ctrl
  import hbs_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ACK_DLY = 2,
  parameter int HOLD    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_strap,
  input  logic              cs_s_n,
  input  logic              s0_s_n,
  input  logic              s1_s_n,
  input  logic [DATA_W-1:0] rdata,
  output logic              we,
  output logic              ack_q,
  output logic              oe_q,
  output logic [DATA_W-1:0] dout_q
);
  localparam int MAXC  = (ACK_DLY > HOLD) ? ACK_DLY : HOLD;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] RD_LIM   = CNT_W'(ACK_DLY - 1);
  localparam logic [CNT_W-1:0] HOLD_LIM = CNT_W'(HOLD - 1);

  mode_t            mode_q;
  logic             armed_q;
  bus_st_t          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             kind_rd_q;

  // strap capture: once per reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_IDLE1;
      armed_q <= 1'b0;
    end else if (!armed_q) begin
      mode_q  <= mode_t'(mode_strap);
      armed_q <= 1'b1;
    end
  end

  logic sep, shr, par, rd_req, wr_req, busy;
  logic [CNT_W-1:0] lim;

  always_comb begin
    sep    = armed_q && (mode_q == MODE_SEP);
    shr    = armed_q && (mode_q == MODE_SHR);
    par    = sep || shr;
    rd_req = !cs_s_n && ((sep && !s0_s_n) || (shr && !s0_s_n && s1_s_n));
    wr_req = !cs_s_n && ((sep && s0_s_n && !s1_s_n) || (shr && !s0_s_n && !s1_s_n));
    busy   = !cs_s_n && ((sep && (!s0_s_n || !s1_s_n)) || (shr && !s0_s_n));
    lim    = kind_rd_q ? RD_LIM : '0;
    we     = (st_q == ST_IDLE) && wr_req && !rd_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      kind_rd_q <= 1'b0;
      ack_q     <= 1'b0;
      oe_q      <= 1'b0;
      dout_q    <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (rd_req) begin
            st_q      <= ST_WAIT;
            kind_rd_q <= 1'b1;
            oe_q      <= 1'b1;
            dout_q    <= rdata;
            cnt_q     <= '0;
          end else if (wr_req) begin
            st_q      <= ST_WAIT;
            kind_rd_q <= 1'b0;
            cnt_q     <= '0;
          end
        end
        ST_WAIT: begin
          if (!busy) begin
            st_q <= ST_IDLE;
            oe_q <= 1'b0;
          end else if (cnt_q == lim) begin
            ack_q <= 1'b1;
            st_q  <= ST_ACK;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_ACK: begin
          if (!busy) begin
            st_q  <= ST_HOLD;
            cnt_q <= '0;
          end
        end
        ST_HOLD: begin
          if (cnt_q == HOLD_LIM) begin
            ack_q <= 1'b0;
            oe_q  <= 1'b0;
            st_q  <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R3
  idle_strap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !par |-> (!ack_q && !oe_q));

  // R4
  strap_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(armed_q)) |-> $stable(mode_q));

  // R7
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> !we);

  // R6
  data_before_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ack_q) && kind_rd_q) |-> $past(oe_q));

  // R8
  release_from_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_q) |-> ($past(st_q) == ST_HOLD));

  // R10
  oe_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ack_q) && kind_rd_q) |-> $fell(oe_q));
endmodule

// File: rtl/hostbus_slave.sv
module hostbus_slave #(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 16,
  parameter int NREGS   = 16,
  parameter int ACK_DLY = 2,
  parameter int HOLD    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_strap,
  input  logic              cs_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              strobe0_n,
  input  logic              strobe1_n,
  input  logic              bhe_n,
  input  logic              ble_n,
  input  logic [DATA_W-1:0] d_in,
  output logic [DATA_W-1:0] d_out,
  output logic              d_oe,
  output logic              ack_n,
  output logic              ack_oe
);
  localparam int LANES = DATA_W / 8;

  logic [2:0]        sync_out;
  logic              we, ack_q, oe_q;
  logic [DATA_W-1:0] rdata, dout_q;
  logic [LANES-1:0]  lane_en;

  hbs_sync #(.WIDTH(3)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({cs_n, strobe0_n, strobe1_n}),
    .dout (sync_out)
  );

  // R9: upper half of the lanes follows bhe_n, lower half ble_n
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (l >= LANES / 2) begin : g_hi
      assign lane_en[l] = ~bhe_n;
    end else begin : g_lo
      assign lane_en[l] = ~ble_n;
    end
  end

  hbs_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREGS(NREGS)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (we),
    .lane_en(lane_en),
    .waddr  (addr),
    .wdata  (d_in),
    .raddr  (addr),
    .rdata  (rdata)
  );

  hbs_ctrl #(.DATA_W(DATA_W), .ACK_DLY(ACK_DLY), .HOLD(HOLD)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_strap(mode_strap),
    .cs_s_n    (sync_out[2]),
    .s0_s_n    (sync_out[1]),
    .s1_s_n    (sync_out[0]),
    .rdata     (rdata),
    .we        (we),
    .ack_q     (ack_q),
    .oe_q      (oe_q),
    .dout_q    (dout_q)
  );

  // R5: open-drain style acknowledge, gated by the raw chip select
  assign ack_oe = ack_q & ~cs_n;
  assign ack_n  = ~ack_oe;
  assign d_oe   = oe_q & ~cs_n;
  assign d_out  = dout_q;

  // R5
  ack_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_oe |-> (!ack_n && !cs_n));
endmodule

// File: tb/tb_hostbus_slave.sv
module tb_hostbus_slave;
  localparam int AW = 10, DW = 16, NR = 16, AD = 2, HD = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, cs_n, strobe0_n, strobe1_n, bhe_n, ble_n;
  logic [1:0]    mode_strap;
  logic [AW-1:0] addr;
  logic [DW-1:0] d_in, d_out;
  logic          d_oe, ack_n, ack_oe;

  hostbus_slave #(.ADDR_W(AW), .DATA_W(DW), .NREGS(NR), .ACK_DLY(AD), .HOLD(HD)) dut (
    .clk(clk), .rst_n(rst_n), .mode_strap(mode_strap), .cs_n(cs_n), .addr(addr),
    .strobe0_n(strobe0_n), .strobe1_n(strobe1_n), .bhe_n(bhe_n), .ble_n(ble_n),
    .d_in(d_in), .d_out(d_out), .d_oe(d_oe), .ack_n(ack_n), .ack_oe(ack_oe)
  );

  int errs = 0, checks = 0;
  logic [DW-1:0] model [NR];
  bit shared_style;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] d,
                                          logic hi_n, logic lo_n);
    logic [DW-1:0] r = old;
    if (!hi_n) r[15:8] = d[15:8];
    if (!lo_n) r[7:0]  = d[7:0];
    return r;
  endfunction

  function automatic logic [DW-1:0] expect_rd(logic [AW-1:0] a);
    return (a < NR) ? model[a[3:0]] : '0;
  endfunction

  task automatic do_reset(logic [1:0] strap);
    @(negedge clk);
    rst_n = 1'b0; mode_strap = strap; cs_n = 1'b1;
    strobe0_n = 1'b1; strobe1_n = 1'b1; bhe_n = 1'b1; ble_n = 1'b1;
    addr = '0; d_in = '0;
    for (int i = 0; i < NR; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12
    chk("R12", "ack_oe after reset", ack_oe, 0);
    chk("R12", "d_oe after reset", d_oe, 0);
    chk("R12", "ack_n after reset", ack_n, 1);
  endtask

  task automatic count_until_ack(bit want, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (ack_oe != want && n < 30);
  endtask

  task automatic bus_write(logic [AW-1:0] a, logic [DW-1:0] d, logic hi_n, logic lo_n);
    int n;
    @(negedge clk);
    cs_n = 1'b0; addr = a; d_in = d; bhe_n = hi_n; ble_n = lo_n;
    if (shared_style) strobe1_n = 1'b0;
    @(negedge clk);
    if (shared_style) strobe0_n = 1'b0; else strobe1_n = 1'b0;
    count_until_ack(1'b1, n);
    chk("R7", "write ack edge", n, 4);
    chk("R5", "ack_n low while driven", ack_n, 0);
    if (shared_style) strobe0_n = 1'b1; else strobe1_n = 1'b1;
    count_until_ack(1'b0, n);
    chk("R8", "write ack release edge", n, 3 + HD);
    cs_n = 1'b1; strobe1_n = 1'b1; bhe_n = 1'b1; ble_n = 1'b1;
    if (a < NR) model[a[3:0]] = merge(model[a[3:0]], d, hi_n, lo_n);
    @(negedge clk);
  endtask

  task automatic bus_read(logic [AW-1:0] a, string req);
    int n, oe_at;
    logic [DW-1:0] exp_d;
    exp_d = expect_rd(a);
    @(negedge clk);
    cs_n = 1'b0; addr = a;
    if (shared_style) strobe1_n = 1'b1;
    @(negedge clk);
    strobe0_n = 1'b0;
    n = 0; oe_at = 0;
    do begin
      @(negedge clk);
      n++;
      if (d_oe && oe_at == 0) oe_at = n;
    end while (!ack_oe && n < 30);
    chk("R6", "read oe edge", oe_at, 3);
    chk("R6", "read ack edge", n, 3 + AD);
    chk(req, "read data", d_out, exp_d);
    strobe0_n = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (ack_oe) chk("R10", "oe held with ack", d_oe, 1);
    end while (ack_oe && n < 30);
    chk("R8", "read ack release edge", n, 3 + HD);
    chk("R10", "oe released with ack", d_oe, 0);
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic random_ops(int count);
    for (int i = 0; i < count; i++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      logic hi_n, lo_n;
      if ($urandom % 4 != 0) a = AW'($urandom % NR);
      else a = AW'(NR + ($urandom % ((1 << AW) - NR)));
      d = DW'($urandom);
      hi_n = 1'($urandom); lo_n = 1'($urandom);
      if ($urandom % 2 == 0) bus_write(a, d, hi_n, lo_n);
      else bus_read(a, shared_style ? "R2" : "R1");
    end
  endtask

  bit done = 1'b0;

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0;
    shared_style = 1'b0;
    do_reset(2'b00);

    // R1, R9: separate-strobe style, lane merging
    bus_write(10'h003, 16'hA1B2, 1'b0, 1'b0);
    bus_read(10'h003, "R1");
    bus_write(10'h003, 16'hFFCC, 1'b1, 1'b0);
    bus_read(10'h003, "R9");
    bus_write(10'h003, 16'h77EE, 1'b0, 1'b1);
    bus_read(10'h003, "R9");

    // R11: out-of-range write must not alias onto register 0 or 3
    bus_write(10'h010, 16'h1234, 1'b0, 1'b0);
    bus_write(10'h3F3, 16'h5678, 1'b0, 1'b0);
    bus_read(10'h000, "R11");
    bus_read(10'h003, "R11");
    bus_read(10'h013, "R11");

    // R5: chip select rising early releases the acknowledge at once
    @(negedge clk);
    cs_n = 1'b0; addr = 10'h003;
    @(negedge clk);
    strobe0_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R5", "ack driven before cs rise", ack_oe, 1);
    cs_n = 1'b1;
    #1;
    chk("R5", "ack_oe drops with cs", ack_oe, 0);
    chk("R5", "ack_n released with cs", ack_n, 1);
    chk("R10", "d_oe drops with cs", d_oe, 0);
    strobe0_n = 1'b1;
    repeat (8) @(negedge clk);

    random_ops(60);

    // R4: strap change without reset keeps the separate-strobe style
    mode_strap = 2'b01;
    bus_write(10'h005, 16'hBEEF, 1'b0, 1'b0);
    bus_read(10'h005, "R4");

    // R2: shared-strobe style after reset
    shared_style = 1'b1;
    do_reset(2'b01);
    bus_write(10'h007, 16'hC0DE, 1'b0, 1'b0);
    bus_read(10'h007, "R2");
    bus_read(10'h002, "R12");
    random_ops(60);

    // R3: idle straps never answer
    for (int s = 2; s < 4; s++) begin
      int seen_ack, seen_oe;
      do_reset(2'(s));
      seen_ack = 0; seen_oe = 0;
      @(negedge clk);
      cs_n = 1'b0; addr = 10'h001;
      strobe0_n = 1'b0; strobe1_n = 1'b0;
      repeat (12) begin
        @(negedge clk);
        if (ack_oe) seen_ack++;
        if (d_oe) seen_oe++;
      end
      chk("R3", "ack on idle strap", seen_ack, 0);
      chk("R3", "oe on idle strap", seen_oe, 0);
      cs_n = 1'b1; strobe0_n = 1'b1; strobe1_n = 1'b1;
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule